// File: doc/BRIEF.md
# Channel Start-Up Window and Fault Latch Supervisor

This block supervises one step-down converter channel. Once the internal supply is past its lockout threshold and the channel is requested on, it opens a start-up window whose length is counted in oscillator ticks. The window closes successfully on the first tick at which the output is seen within 1% of its target. If the count runs out first, the channel is shut down as an undervoltage fault.

After start-up, two comparator flags are watched: output below 70% of target, and output above 150%. Either one latches the channel off. While the latch is set, the supervisor drives a fault-force output that holds the high-side switch off and the low-side switch on. Only the power-on reset clears a latched fault, and that reset stands in for cycling the supply. While start-up is in progress, the startup-active output tells neighbouring logic to blank the low-output protections. A 3-bit status code reports the channel's condition.

Top module: `ssf_supervisor`

## Requirements
- R1: After `rst_ni` is asserted, `status_o` is 0 (idle), and `startup_o`, `chan_en_o` and `fault_force_o` are all low.
- R2: Start-up begins only in a cycle where both `supply_ok_i` and `on_req_i` are high. One clock later, `startup_o` and `chan_en_o` are high and `status_o` is 1 (starting).
- R3: Start-up ends on the first cycle in which `osc_tick_i` and `in_reg_i` are both high. One clock later, `status_o` is 2 (regulating), `startup_o` is low and `chan_en_o` stays high. A high `in_reg_i` without a tick has no effect.
- R4: If WINDOW ticks pass during start-up with `in_reg_i` low on every one of them, the WINDOW-th tick latches an undervoltage fault: `status_o` becomes 3. If `in_reg_i` is high on that last tick, the channel regulates instead. Cycles without a tick do not advance the count.
- R5: During start-up, `uv_flag_i` is ignored.
- R6: While regulating, a high `uv_flag_i` latches an undervoltage fault (`status_o` 3).
- R7: While starting or regulating, a high `ov_flag_i` latches an overvoltage fault (`status_o` 4).
- R8: If both faults would latch in the same cycle, the overvoltage fault wins (`status_o` 4).
- R9: While a fault is latched, `fault_force_o` is high and `chan_en_o` and `startup_o` are low. The fault persists regardless of `on_req_i`, `supply_ok_i` or further flags, and only `rst_ni` clears it.
- R10: Dropping `on_req_i` or `supply_ok_i` while starting or regulating returns the channel to idle with no fault. A later start gets a fresh, full window.
- R11: While idle, `uv_flag_i` and `ov_flag_i` latch no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| osc_tick_i | input | 1 | One-cycle pulse per oscillator period |
| supply_ok_i | input | 1 | Internal supply above lockout threshold |
| on_req_i | input | 1 | Channel on request |
| in_reg_i | input | 1 | Output within 1% of target |
| uv_flag_i | input | 1 | Output below 70% of target |
| ov_flag_i | input | 1 | Output above 150% of target |
| startup_o | output | 1 | Start-up in progress (blanking for other protections) |
| chan_en_o | output | 1 | Channel switching enabled |
| fault_force_o | output | 1 | Latched fault: high side off, low side on |
| status_o | output | 3 | 0 idle, 1 starting, 2 regulating, 3 UV latched, 4 OV latched |

## Verification
Every output is decoded from state registers. Each result is therefore due exactly one clock edge after the cycle that presents its stimulus: a start request, a tick, a fault flag or a dropped request. The bench drives inputs on the falling edge, lets one rising edge pass, and samples at the next falling edge. For the window, it counts ticks itself and places idle cycles between them, so that it checks the WINDOW-1 and WINDOW-th tick boundaries in the cycle each one lands.

// File: rtl/ssf_pkg.sv
package ssf_pkg;
  typedef enum logic [1:0] {
    RUN_IDLE  = 2'd0,
    RUN_START = 2'd1,
    RUN_REG   = 2'd2
  } run_e;

  typedef enum logic [2:0] {
    STAT_IDLE  = 3'd0,
    STAT_START = 3'd1,
    STAT_REG   = 3'd2,
    STAT_UV    = 3'd3,
    STAT_OV    = 3'd4
  } stat_e;
endpackage

// File: rtl/ssf_window_timer.sv
module ssf_window_timer #(
  parameter int unsigned WINDOW = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic tick_i,
  output logic last_o
);
  localparam int unsigned CW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

  logic [CW-1:0] cnt_q;

  assign last_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clear_i)            cnt_q <= '0;
    else if (tick_i && !last_o)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ssf_fault_latch.sv
module ssf_fault_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_uv_i,
  input  logic set_ov_i,
  output logic uv_o,
  output logic ov_o
);
  logic uv_q, ov_q;

  // first fault wins; OV has priority when both arrive together
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uv_q <= 1'b0;
      ov_q <= 1'b0;
    end else if (!uv_q && !ov_q) begin
      if (set_ov_i)      ov_q <= 1'b1;
      else if (set_uv_i) uv_q <= 1'b1;
    end
  end

  assign uv_o = uv_q;
  assign ov_o = ov_q;
endmodule

// File: rtl/ssf_run_ctrl.sv
module ssf_run_ctrl
  import ssf_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic supply_ok_i,
  input  logic on_req_i,
  input  logic in_reg_i,
  input  logic uv_flag_i,
  input  logic ov_flag_i,
  input  logic win_last_i,
  input  logic faulted_i,
  output run_e state_o,
  output logic set_uv_o,
  output logic set_ov_o,
  output logic timer_clear_o,
  output logic timer_tick_o
);
  run_e state_q, state_d;
  logic go_on;
  logic active;

  assign go_on  = supply_ok_i && on_req_i;
  assign active = (state_q != RUN_IDLE);

  always_comb begin
    set_ov_o = !faulted_i && active && ov_flag_i;
    set_uv_o = !faulted_i &&
               (((state_q == RUN_REG) && uv_flag_i) ||
                ((state_q == RUN_START) && tick_i && !in_reg_i && win_last_i));
  end

  always_comb begin
    state_d = state_q;
    if (faulted_i || set_ov_o || set_uv_o) begin
      state_d = RUN_IDLE;
    end else begin
      unique case (state_q)
        RUN_IDLE:  if (go_on) state_d = RUN_START;
        RUN_START: begin
          if (!go_on)                  state_d = RUN_IDLE;
          else if (tick_i && in_reg_i) state_d = RUN_REG;
        end
        RUN_REG:   if (!go_on) state_d = RUN_IDLE;
        default:   state_d = RUN_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= RUN_IDLE;
    else         state_q <= state_d;
  end

  assign state_o       = state_q;
  assign timer_clear_o = (state_q != RUN_START);
  assign timer_tick_o  = tick_i && (state_q == RUN_START);
endmodule

// File: rtl/ssf_supervisor.sv
module ssf_supervisor
  import ssf_pkg::*;
#(
  parameter int unsigned WINDOW = 4096
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       osc_tick_i,
  input  logic       supply_ok_i,
  input  logic       on_req_i,
  input  logic       in_reg_i,
  input  logic       uv_flag_i,
  input  logic       ov_flag_i,
  output logic       startup_o,
  output logic       chan_en_o,
  output logic       fault_force_o,
  output logic [2:0] status_o
);
  run_e state;
  logic set_uv, set_ov, uv_lat, ov_lat;
  logic t_clear, t_tick, t_last;

  ssf_run_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (osc_tick_i),
    .supply_ok_i  (supply_ok_i),
    .on_req_i     (on_req_i),
    .in_reg_i     (in_reg_i),
    .uv_flag_i    (uv_flag_i),
    .ov_flag_i    (ov_flag_i),
    .win_last_i   (t_last),
    .faulted_i    (uv_lat || ov_lat),
    .state_o      (state),
    .set_uv_o     (set_uv),
    .set_ov_o     (set_ov),
    .timer_clear_o(t_clear),
    .timer_tick_o (t_tick)
  );

  ssf_window_timer #(.WINDOW(WINDOW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(t_clear),
    .tick_i (t_tick),
    .last_o (t_last)
  );

  ssf_fault_latch u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_uv_i(set_uv),
    .set_ov_i(set_ov),
    .uv_o    (uv_lat),
    .ov_o    (ov_lat)
  );

  stat_e stat;
  always_comb begin
    if (ov_lat)                  stat = STAT_OV;
    else if (uv_lat)             stat = STAT_UV;
    else if (state == RUN_START) stat = STAT_START;
    else if (state == RUN_REG)   stat = STAT_REG;
    else                         stat = STAT_IDLE;
  end

  assign status_o      = stat;
  assign startup_o     = (state == RUN_START);
  assign chan_en_o     = (state != RUN_IDLE);
  assign fault_force_o = uv_lat || ov_lat;
endmodule

// File: rtl/ssf_supervisor_chk.sv
module ssf_supervisor_chk #(
  parameter int unsigned WINDOW = 4096
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       osc_tick_i,
  input logic       supply_ok_i,
  input logic       on_req_i,
  input logic       in_reg_i,
  input logic       uv_flag_i,
  input logic       ov_flag_i,
  input logic       startup_o,
  input logic       chan_en_o,
  input logic       fault_force_o,
  input logic [2:0] status_o
);
  localparam int unsigned KW = $clog2(WINDOW + 2);
  logic [KW-1:0] tick_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      tick_seen <= '0;
    else if (!startup_o)              tick_seen <= '0;
    else if (osc_tick_i)              tick_seen <= tick_seen + 1'b1;
  end

  a_r1_reset_idle: assert property (@(posedge clk_i)
    !rst_ni |=> (status_o == 3'd0 || !rst_ni));

  a_r3_tick_ends_startup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (startup_o && osc_tick_i && in_reg_i && !ov_flag_i && on_req_i && supply_ok_i)
      |=> (status_o == 3'd2));

  a_r4_window_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    startup_o |-> (tick_seen < KW'(WINDOW)));

  a_r5_uv_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (startup_o && uv_flag_i && !osc_tick_i && !ov_flag_i) |=> (status_o != 3'd3));

  a_r7_ov_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_en_o && ov_flag_i) |=> (status_o == 3'd4));

  a_r9_fault_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_force_o |=> (fault_force_o && $stable(status_o)));

  a_r9_fault_forces_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_force_o |-> (!chan_en_o && !startup_o));

  a_r11_idle_no_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chan_en_o && !fault_force_o) |=> !fault_force_o);
endmodule

bind ssf_supervisor ssf_supervisor_chk #(.WINDOW(WINDOW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .osc_tick_i   (osc_tick_i),
  .supply_ok_i  (supply_ok_i),
  .on_req_i     (on_req_i),
  .in_reg_i     (in_reg_i),
  .uv_flag_i    (uv_flag_i),
  .ov_flag_i    (ov_flag_i),
  .startup_o    (startup_o),
  .chan_en_o    (chan_en_o),
  .fault_force_o(fault_force_o),
  .status_o     (status_o)
);

// File: tb/ssf_supervisor_bench.sv
module ssf_supervisor_bench;
  localparam int unsigned WIN = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, sup = 1'b0, onr = 1'b0, inr = 1'b0, uvf = 1'b0, ovf = 1'b0;
  logic st_o, en_o, ff_o;
  logic [2:0] stat_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ssf_supervisor #(.WINDOW(WIN)) u_ssf_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .osc_tick_i(tick), .supply_ok_i(sup),
    .on_req_i(onr), .in_reg_i(inr), .uv_flag_i(uvf), .ov_flag_i(ovf),
    .startup_o(st_o), .chan_en_o(en_o), .fault_force_o(ff_o), .status_o(stat_o)
  );

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // pack {status, startup, chan_en, fault_force}
  function automatic logic [5:0] outs();
    return {stat_o, st_o, en_o, ff_o};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    {tick, sup, onr, inr, uvf, ovf} = '0;
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic pulse_tick(input logic reg_ok);
    tick = 1'b1; inr = reg_ok;
    step();
    tick = 1'b0; inr = 1'b0;
  endtask

  task automatic go_start();
    sup = 1'b1; onr = 1'b1;
    step();
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 reset", outs(), {3'd0, 3'b000});
  endtask

  task automatic t_start_gate();
    do_reset();
    ovf = 1'b1; uvf = 1'b1;
    step();
    check("R11 idle flags", outs(), {3'd0, 3'b000});
    ovf = 1'b0; uvf = 1'b0;
    onr = 1'b1;
    step();
    check("R2 no supply", outs(), {3'd0, 3'b000});
    sup = 1'b1; onr = 1'b0;
    step();
    check("R2 no request", outs(), {3'd0, 3'b000});
    onr = 1'b1;
    step();
    check("R2 start", outs(), {3'd1, 3'b110});
  endtask

  task automatic t_early_done();
    do_reset();
    go_start();
    inr = 1'b1;
    step(); step();
    check("R3 no tick", outs(), {3'd1, 3'b110});
    inr = 1'b0;
    pulse_tick(1'b1);
    check("R3 done", outs(), {3'd2, 3'b010});
  endtask

  task automatic t_uv_path();
    do_reset();
    go_start();
    uvf = 1'b1;
    for (int i = 0; i < 3; i++) begin
      pulse_tick(1'b0);
      uvf = 1'b1;
    end
    step();
    check("R5 uv masked", outs(), {3'd1, 3'b110});
    uvf = 1'b0;
    pulse_tick(1'b1);
    check("R3 reg", outs(), {3'd2, 3'b010});
    uvf = 1'b1;
    step();
    uvf = 1'b0;
    check("R6 uv latch", outs(), {3'd3, 3'b001});
    onr = 1'b0; sup = 1'b0; ovf = 1'b1;
    step(); step();
    check("R9 sticky", outs(), {3'd3, 3'b001});
    ovf = 1'b0; onr = 1'b1; sup = 1'b1;
    step(); step();
    check("R9 no restart", outs(), {3'd3, 3'b001});
    do_reset();
    check("R9 reset clears", outs(), {3'd0, 3'b000});
  endtask

  task automatic t_window();
    do_reset();
    go_start();
    for (int i = 0; i < WIN - 1; i++) begin
      pulse_tick(1'b0);
      step();
    end
    check("R4 before last", outs(), {3'd1, 3'b110});
    pulse_tick(1'b0);
    check("R4 expiry", outs(), {3'd3, 3'b001});
    do_reset();
    go_start();
    for (int i = 0; i < WIN - 1; i++) pulse_tick(1'b0);
    pulse_tick(1'b1);
    check("R4 last tick ok", outs(), {3'd2, 3'b010});
  endtask

  task automatic t_ov();
    do_reset();
    go_start();
    ovf = 1'b1;
    step();
    ovf = 1'b0;
    check("R7 ov in start", outs(), {3'd4, 3'b001});
    do_reset();
    go_start();
    pulse_tick(1'b1);
    ovf = 1'b1; uvf = 1'b1;
    step();
    ovf = 1'b0; uvf = 1'b0;
    check("R8 ov priority", outs(), {3'd4, 3'b001});
  endtask

  task automatic t_abort();
    do_reset();
    go_start();
    for (int i = 0; i < 5; i++) pulse_tick(1'b0);
    onr = 1'b0;
    step();
    check("R10 drop req", outs(), {3'd0, 3'b000});
    onr = 1'b1;
    step();
    for (int i = 0; i < WIN - 1; i++) pulse_tick(1'b0);
    check("R10 fresh window", outs(), {3'd1, 3'b110});
    pulse_tick(1'b1);
    sup = 1'b0;
    step();
    check("R10 drop supply", outs(), {3'd0, 3'b000});
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_start_gate();
    t_early_done();
    t_uv_path();
    t_window();
    t_ov();
    t_abort();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule